// File: doc/BRIEF.md
# Bus Cycle Breakpoint Match Channel

This block is one channel of a hardware breakpoint unit. It watches every CPU bus cycle presented on its input strobe and raises a break request when the cycle meets the conditions held in its registers. The conditions are the kind of cycle (instruction fetch or operand access), the transfer direction, the bus that carries an operand access, a masked address compare and an optional masked data compare that also checks the access size.

Software sets up the channel through a small write/read register port. The registers are a control word, an address match value and its mask, and a data match value and its mask. When a qualifying cycle is strobed, the channel drives a single-clock pulse in the following clock. For 64-bit transfers the two 32-bit halves of the bus data are each tested against the same 32-bit match data and mask, and a hit on either half is enough.

Top module: `bkpt_chan`

## Requirements
- R1: After reset every register reads back as zero and `brk_pulse` is low, so the channel starts disabled.
- R2: While the enable bit (control bit 0) is 0 the channel never pulses, whatever the other fields hold.
- R3: The cycle-kind field (control bits 2:1) set to 01 accepts only fetch cycles (`cyc_fetch`=1), 10 accepts only operand cycles, and 00 or 11 accept both.
- R4: The direction field (control bits 4:3) is checked only when the cycle-kind field is 10. Then 01 accepts only reads (`cyc_wr`=0), 10 accepts only writes, and 00 or 11 accept both. With any other cycle-kind value the direction is ignored.
- R5: The bus field (control bits 6:5) is checked only when the cycle-kind field is 10. Then 00 (operand bus) allows a match and any other value blocks every match. With any other cycle-kind value the bus field is ignored.
- R6: The address matches when every bit whose address-mask bit is 0 equals the address match register. A mask bit of 1 removes that bit from the compare.
- R7: When the data-compare bit (control bit 9) is 1, the cycle's `cyc_size` must equal the size field (control bits 8:7). The size codes are 00 byte, 01 16-bit, 10 32-bit and 11 64-bit. When the data-compare bit is 0, neither data nor size affects the match.
- R8: With data compare on and a size other than 64-bit, `cyc_data[31:0]` is compared with the data match register, and data-mask bits of 1 are excluded from the compare.
- R9: With data compare on and a 64-bit size, the channel matches when either `cyc_data[63:32]` or `cyc_data[31:0]` passes the masked compare against the same 32-bit match data.
- R10: `brk_pulse` is high for exactly the one clock after a qualifying strobe. It is never high after a clock in which `cyc_vld` was low.
- R11: The register port decodes `reg_addr` as 0 control (10 bits), 1 address match, 2 address mask, 3 data match and 4 data mask. Reads are combinational, and any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| cyc_vld | input | 1 | Bus cycle valid strobe |
| cyc_fetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| cyc_wr | input | 1 | 1 = write, 0 = read |
| cyc_size | input | 2 | Access size code |
| cyc_addr | input | ADDR_W | Cycle address |
| cyc_data | input | 64 | Cycle data |
| brk_pulse | output | 1 | One-clock break request |

## Verification
The assertions assume that the control register does not change in the clock in which a cycle is strobed. This is because the pulse reflects the settings sampled at that strobe. The bench therefore writes registers only while `cyc_vld` is low. It holds each cycle strobe for one clock and samples the result on the falling edges that follow. The bench also assumes the strobe is never high during reset.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  localparam logic [1:0] KIND_FETCH = 2'b01;
  localparam logic [1:0] KIND_OPND  = 2'b10;
  localparam logic [1:0] DIR_READ   = 2'b01;
  localparam logic [1:0] DIR_WRITE  = 2'b10;
  localparam logic [1:0] SZ_QUAD    = 2'b11;

  typedef struct packed {
    logic       den;
    logic [1:0] size;
    logic [1:0] bus;
    logic [1:0] dir;
    logic [1:0] kind;
    logic       en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  function automatic logic kind_pass(input logic [1:0] kind, input logic fetch);
    case (kind)
      KIND_FETCH: return fetch;
      KIND_OPND:  return !fetch;
      default:    return 1'b1;
    endcase
  endfunction

  function automatic logic dir_pass(input logic [1:0] kind, input logic [1:0] dir,
                                    input logic wr);
    if (kind != KIND_OPND) return 1'b1;
    case (dir)
      DIR_READ:  return !wr;
      DIR_WRITE: return wr;
      default:   return 1'b1;
    endcase
  endfunction

  function automatic logic bus_pass(input logic [1:0] kind, input logic [1:0] bus);
    return (kind != KIND_OPND) || (bus == 2'b00);
  endfunction

  function automatic logic masked_eq32(input logic [31:0] v, input logic [31:0] ref_v,
                                       input logic [31:0] msk);
    return ((v ^ ref_v) & ~msk) == 32'd0;
  endfunction

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output ctl_t              ctl,
  output logic [ADDR_W-1:0] amatch,
  output logic [ADDR_W-1:0] amask,
  output logic [31:0]       dmatch,
  output logic [31:0]       dmask
);

  localparam logic [2:0] A_CTL = 3'd0;
  localparam logic [2:0] A_AMT = 3'd1;
  localparam logic [2:0] A_AMK = 3'd2;
  localparam logic [2:0] A_DMT = 3'd3;
  localparam logic [2:0] A_DMK = 3'd4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl    <= '0;
      amatch <= '0;
      amask  <= '0;
      dmatch <= '0;
      dmask  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTL:   ctl    <= ctl_t'(reg_wdata[CTL_W-1:0]);
        A_AMT:   amatch <= reg_wdata[ADDR_W-1:0];
        A_AMK:   amask  <= reg_wdata[ADDR_W-1:0];
        A_DMT:   dmatch <= reg_wdata;
        A_DMK:   dmask  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTL:   reg_rdata[CTL_W-1:0]  = ctl;
      A_AMT:   reg_rdata[ADDR_W-1:0] = amatch;
      A_AMK:   reg_rdata[ADDR_W-1:0] = amask;
      A_DMT:   reg_rdata             = dmatch;
      A_DMK:   reg_rdata             = dmask;
      default: reg_rdata             = '0;
    endcase
  end

endmodule

// File: rtl/bkpt_qual.sv
module bkpt_qual
  import bkpt_pkg::*;
(
  input  ctl_t ctl,
  input  logic cyc_fetch,
  input  logic cyc_wr,
  output logic kind_ok,
  output logic dir_ok,
  output logic bus_ok
);

  assign kind_ok = kind_pass(ctl.kind, cyc_fetch);
  assign dir_ok  = dir_pass(ctl.kind, ctl.dir, cyc_wr);
  assign bus_ok  = bus_pass(ctl.kind, ctl.bus);

endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  ctl_t              ctl,
  input  logic [1:0]        cyc_size,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [63:0]       cyc_data,
  input  logic [ADDR_W-1:0] amatch,
  input  logic [ADDR_W-1:0] amask,
  input  logic [31:0]       dmatch,
  input  logic [31:0]       dmask,
  output logic              addr_hit,
  output logic              data_hit
);

  logic lo_hit, hi_hit, size_ok;

  assign addr_hit = ((cyc_addr ^ amatch) & ~amask) == '0;
  assign lo_hit   = masked_eq32(cyc_data[31:0],  dmatch, dmask);
  assign hi_hit   = masked_eq32(cyc_data[63:32], dmatch, dmask);
  assign size_ok  = (cyc_size == ctl.size);

  always_comb begin
    if (!ctl.den)                data_hit = 1'b1;
    else if (!size_ok)           data_hit = 1'b0;
    else if (cyc_size == SZ_QUAD) data_hit = lo_hit | hi_hit;
    else                         data_hit = lo_hit;
  end

endmodule

// File: rtl/bkpt_chan.sv
module bkpt_chan
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cyc_vld,
  input  logic              cyc_fetch,
  input  logic              cyc_wr,
  input  logic [1:0]        cyc_size,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [63:0]       cyc_data,
  output logic              brk_pulse
);

  ctl_t              ctl;
  logic [ADDR_W-1:0] amatch, amask;
  logic [31:0]       dmatch, dmask;
  logic              kind_ok, dir_ok, bus_ok, addr_hit, data_hit, cyc_hit;

  // named control fields for the bound checker
  logic       ctl_en, ctl_den;
  logic [1:0] ctl_kind, ctl_dir, ctl_bus, ctl_size;
  assign ctl_en   = ctl.en;
  assign ctl_den  = ctl.den;
  assign ctl_kind = ctl.kind;
  assign ctl_dir  = ctl.dir;
  assign ctl_bus  = ctl.bus;
  assign ctl_size = ctl.size;

  bkpt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl(ctl),
    .amatch(amatch), .amask(amask), .dmatch(dmatch), .dmask(dmask)
  );

  bkpt_qual u_qual (
    .ctl(ctl), .cyc_fetch(cyc_fetch), .cyc_wr(cyc_wr),
    .kind_ok(kind_ok), .dir_ok(dir_ok), .bus_ok(bus_ok)
  );

  bkpt_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .ctl(ctl), .cyc_size(cyc_size), .cyc_addr(cyc_addr), .cyc_data(cyc_data),
    .amatch(amatch), .amask(amask), .dmatch(dmatch), .dmask(dmask),
    .addr_hit(addr_hit), .data_hit(data_hit)
  );

  assign cyc_hit = cyc_vld & ctl.en & kind_ok & dir_ok & bus_ok & addr_hit & data_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) brk_pulse <= 1'b0;
    else        brk_pulse <= cyc_hit;
  end

endmodule

// File: rtl/bkpt_chan_chk.sv
module bkpt_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_vld,
  input logic       cyc_fetch,
  input logic       cyc_wr,
  input logic [1:0] cyc_size,
  input logic       brk_pulse,
  input logic       ctl_en,
  input logic       ctl_den,
  input logic [1:0] ctl_kind,
  input logic [1:0] ctl_dir,
  input logic [1:0] ctl_bus,
  input logic [1:0] ctl_size,
  input logic       addr_hit,
  input logic       data_hit
);

  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !brk_pulse);

  assert_fetch_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_kind == 2'b01 && !cyc_fetch) |=> !brk_pulse);

  assert_opnd_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_kind == 2'b10 && cyc_fetch) |=> !brk_pulse);

  assert_read_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_kind == 2'b10 && ctl_dir == 2'b01 && cyc_wr) |=> !brk_pulse);

  assert_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_kind == 2'b10 && ctl_dir == 2'b10 && !cyc_wr) |=> !brk_pulse);

  assert_bus_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_kind == 2'b10 && ctl_bus != 2'b00) |=> !brk_pulse);

  assert_addr_need_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |=> !brk_pulse);

  assert_size_need_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_den && cyc_size != ctl_size) |=> !brk_pulse);

  assert_data_need_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !data_hit |=> !brk_pulse);

  assert_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_vld |=> !brk_pulse);

endmodule

bind bkpt_chan bkpt_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .cyc_fetch(cyc_fetch),
  .cyc_wr(cyc_wr), .cyc_size(cyc_size), .brk_pulse(brk_pulse),
  .ctl_en(ctl_en), .ctl_den(ctl_den), .ctl_kind(ctl_kind), .ctl_dir(ctl_dir),
  .ctl_bus(ctl_bus), .ctl_size(ctl_size), .addr_hit(addr_hit), .data_hit(data_hit)
);

// File: tb/sim_bkpt_chan.sv
module sim_bkpt_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cyc_vld = 1'b0, cyc_fetch = 1'b0, cyc_wr = 1'b0;
  logic [1:0]  cyc_size = '0;
  logic [31:0] cyc_addr = '0;
  logic [63:0] cyc_data = '0;
  logic        brk_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bkpt_chan #(.ADDR_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_vld(cyc_vld),
    .cyc_fetch(cyc_fetch), .cyc_wr(cyc_wr), .cyc_size(cyc_size),
    .cyc_addr(cyc_addr), .cyc_data(cyc_data), .brk_pulse(brk_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // control word: den[9] size[8:7] bus[6:5] dir[4:3] kind[2:1] en[0]
  function automatic logic [31:0] cw(input bit en, input logic [1:0] kind,
      input logic [1:0] dir, input logic [1:0] bus, input logic [1:0] size, input bit den);
    return {22'd0, den, size, bus, dir, kind, en};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  // one strobed cycle; pulse expected in the next clock and gone after it
  task automatic bus(input string req, input bit f, input bit w, input logic [1:0] sz,
                     input logic [31:0] a, input logic [63:0] d, input bit exp);
    @(negedge clk);
    cyc_vld = 1'b1; cyc_fetch = f; cyc_wr = w; cyc_size = sz; cyc_addr = a; cyc_data = d;
    @(negedge clk);
    cyc_vld = 1'b0;
    check(req, 32'(brk_pulse), 32'(exp));
    @(negedge clk);
    check({req, "/R10 width"}, 32'(brk_pulse), 32'd0);
  endtask

  task automatic t_reset();
    check("R1 pulse", 32'(brk_pulse), 32'd0);
    for (int i = 0; i < 5; i++) rd("R1 regs", 3'(i), 32'd0);
  endtask

  task automatic t_regmap();
    wr(3'd1, 32'h1234_5678); wr(3'd2, 32'h0000_00FF);
    wr(3'd3, 32'hCAFE_F00D); wr(3'd4, 32'h0F0F_0000);
    wr(3'd0, 32'hFFFF_FFFF);
    rd("R11 ctl", 3'd0, 32'h0000_03FF);
    rd("R11 amatch", 3'd1, 32'h1234_5678);
    rd("R11 amask", 3'd2, 32'h0000_00FF);
    rd("R11 dmatch", 3'd3, 32'hCAFE_F00D);
    rd("R11 dmask", 3'd4, 32'h0F0F_0000);
    rd("R11 unused", 3'd6, 32'd0);
  endtask

  task automatic t_disable();
    wr(3'd2, 32'd0); wr(3'd1, 32'h0000_1000); wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd0, cw(0, 2'b00, 2'b00, 2'b00, 2'b10, 0));
    bus("R2 off fetch", 1, 0, 2'b10, 32'h1000, 64'd0, 0);
    bus("R2 off opnd", 0, 1, 2'b10, 32'h1000, 64'd0, 0);
  endtask

  task automatic t_kind();
    wr(3'd0, cw(1, 2'b00, 2'b00, 2'b00, 2'b00, 0));
    bus("R3 k00 fetch", 1, 0, 2'b10, 32'h1000, 64'd0, 1);
    bus("R3 k00 opnd", 0, 0, 2'b10, 32'h1000, 64'd0, 1);
    wr(3'd0, cw(1, 2'b11, 2'b00, 2'b00, 2'b00, 0));
    bus("R3 k11 fetch", 1, 0, 2'b10, 32'h1000, 64'd0, 1);
    bus("R3 k11 opnd", 0, 1, 2'b10, 32'h1000, 64'd0, 1);
    wr(3'd0, cw(1, 2'b01, 2'b00, 2'b00, 2'b00, 0));
    bus("R3 k01 fetch", 1, 0, 2'b10, 32'h1000, 64'd0, 1);
    bus("R3 k01 opnd", 0, 0, 2'b10, 32'h1000, 64'd0, 0);
    wr(3'd0, cw(1, 2'b10, 2'b00, 2'b00, 2'b00, 0));
    bus("R3 k10 fetch", 1, 0, 2'b10, 32'h1000, 64'd0, 0);
    bus("R3 k10 opnd", 0, 0, 2'b10, 32'h1000, 64'd0, 1);
  endtask

  task automatic t_dir();
    wr(3'd0, cw(1, 2'b10, 2'b01, 2'b00, 2'b00, 0));
    bus("R4 rd-only read", 0, 0, 2'b10, 32'h1000, 64'd0, 1);
    bus("R4 rd-only write", 0, 1, 2'b10, 32'h1000, 64'd0, 0);
    wr(3'd0, cw(1, 2'b10, 2'b10, 2'b00, 2'b00, 0));
    bus("R4 wr-only write", 0, 1, 2'b10, 32'h1000, 64'd0, 1);
    bus("R4 wr-only read", 0, 0, 2'b10, 32'h1000, 64'd0, 0);
    wr(3'd0, cw(1, 2'b10, 2'b11, 2'b00, 2'b00, 0));
    bus("R4 d11 write", 0, 1, 2'b10, 32'h1000, 64'd0, 1);
    wr(3'd0, cw(1, 2'b00, 2'b01, 2'b00, 2'b00, 0));
    bus("R4 ignored write", 0, 1, 2'b10, 32'h1000, 64'd0, 1);
  endtask

  task automatic t_bus();
    wr(3'd0, cw(1, 2'b10, 2'b00, 2'b01, 2'b00, 0));
    bus("R5 rsvd bus", 0, 0, 2'b10, 32'h1000, 64'd0, 0);
    wr(3'd0, cw(1, 2'b10, 2'b00, 2'b11, 2'b00, 0));
    bus("R5 rsvd bus 11", 0, 1, 2'b10, 32'h1000, 64'd0, 0);
    wr(3'd0, cw(1, 2'b00, 2'b00, 2'b10, 2'b00, 0));
    bus("R5 ignored bus", 0, 0, 2'b10, 32'h1000, 64'd0, 1);
  endtask

  task automatic t_addr();
    wr(3'd0, cw(1, 2'b00, 2'b00, 2'b00, 2'b00, 0));
    bus("R6 exact miss", 1, 0, 2'b10, 32'h1004, 64'd0, 0);
    wr(3'd2, 32'h0000_000F);
    bus("R6 masked hit", 1, 0, 2'b10, 32'h100C, 64'd0, 1);
    bus("R6 unmasked miss", 1, 0, 2'b10, 32'h1010, 64'd0, 0);
    bus("R6 high bit miss", 1, 0, 2'b10, 32'h8000_1000, 64'd0, 0);
    wr(3'd2, 32'd0);
  endtask

  task automatic t_data();
    wr(3'd3, 32'hA5A5_1234); wr(3'd4, 32'd0);
    wr(3'd0, cw(1, 2'b10, 2'b00, 2'b00, 2'b10, 1));
    bus("R8 data hit", 0, 1, 2'b10, 32'h1000, 64'h0000_0000_A5A5_1234, 1);
    bus("R8 data miss", 0, 1, 2'b10, 32'h1000, 64'h0000_0000_A5A5_1235, 0);
    bus("R8 upper ignored", 0, 1, 2'b10, 32'h1000, 64'hFFFF_FFFF_A5A5_1234, 1);
    bus("R7 size miss", 0, 1, 2'b01, 32'h1000, 64'h0000_0000_A5A5_1234, 0);
    wr(3'd4, 32'h0000_00FF);
    bus("R8 masked hit", 0, 0, 2'b10, 32'h1000, 64'h0000_0000_A5A5_12CD, 1);
    bus("R8 masked miss", 0, 0, 2'b10, 32'h1000, 64'h0000_0000_A5A4_1234, 0);
    wr(3'd4, 32'd0);
    wr(3'd0, cw(1, 2'b10, 2'b00, 2'b00, 2'b10, 0));
    bus("R7 den off", 0, 0, 2'b00, 32'h1000, 64'h1, 1);
  endtask

  task automatic t_quad();
    wr(3'd0, cw(1, 2'b10, 2'b00, 2'b00, 2'b11, 1));
    bus("R9 upper hit", 0, 1, 2'b11, 32'h1000, 64'hA5A5_1234_0000_0000, 1);
    bus("R9 lower hit", 0, 1, 2'b11, 32'h1000, 64'h0000_0000_A5A5_1234, 1);
    bus("R9 none", 0, 1, 2'b11, 32'h1000, 64'h1111_1111_2222_2222, 0);
    bus("R7 quad vs word", 0, 1, 2'b10, 32'h1000, 64'h0000_0000_A5A5_1234, 0);
  endtask

  task automatic t_strobe();
    wr(3'd0, cw(1, 2'b00, 2'b00, 2'b00, 2'b00, 0));
    @(negedge clk);
    cyc_vld = 1'b0; cyc_addr = 32'h1000;
    @(negedge clk);
    check("R10 no strobe", 32'(brk_pulse), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_disable();
    t_kind();
    t_dir();
    t_bus();
    t_addr();
    t_data();
    t_quad();
    t_strobe();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule